// File: doc/BRIEF.md
# Disk Sector Header Parser

This block follows a floppy read channel after the bit-level decoding stage. After every sync mark it watches the stream of decoded bytes. It works out whether the next record is a sector header, a data block or something it does not know. For a sector header it collects the fields, checks the XOR checksum and checks that the sector number is in range. When the header passes, the block publishes the head position (track and sector) and the two disk identity bytes.

The published values hold until the next good header replaces them. A display or a head-position monitor can therefore read them at any time. Each header ends in exactly one of two single-cycle pulses: one marks acceptance, the other marks rejection. Data blocks, unknown lead bytes, trailing fill bytes and bytes that arrive with no sync before them have no effect.

Top module: `sector_header_parser`

## Requirements
- R1: After reset the four field outputs read 0x00 and both pulses are low.
- R2: After a sync, a first byte of 0x08 starts a header. The following bytes are taken in this fixed order: checksum, sector, track, first ID byte, second ID byte. In the clock cycle after the second ID byte is sampled, either `hdr_ok_o` or `hdr_bad_o` is high.
- R3: The checksum byte must equal sector XOR track XOR first ID XOR second ID. On a mismatch `hdr_bad_o` pulses and all four field outputs keep their previous values.
- R4: A sector value at or above `SECTORS_PER_TRACK` (default 21, so 0 to 20 are legal) is rejected through `hdr_bad_o`, even when the checksum matches. Sector 20 is accepted.
- R5: After a sync, a first byte of 0x07 marks a data block. Every byte up to the next sync is ignored.
- R6: After a sync, a first byte other than 0x07 or 0x08 makes the parser ignore every byte until the next sync.
- R7: A sync that arrives partway through a header drops the partial header with no pulse. The next byte is treated as a lead byte.
- R8: Bytes after the second ID byte (the fill bytes, normally 0x0F) are not checked. Neither they nor any bytes up to the next sync can cause a pulse.
- R9: The byte sequence 08 1F 00 12 A0 AD 0F 0F gives track 0x12 (18), sector 0x00, ID bytes 0xA0 and 0xAD, and an `hdr_ok_o` pulse.
- R10: When a sync and a byte strobe fall in the same cycle, the sync wins and that byte is dropped.
- R11: On a good header, `hdr_ok_o` is high for one cycle and the field outputs update in that same cycle. `hdr_ok_o` and `hdr_bad_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | One-cycle pulse: a sync mark was seen |
| byte_vld_i | input | 1 | Strobe: `byte_i` carries a decoded byte |
| byte_i | input | 8 | Decoded byte |
| track_o | output | 8 | Track of the last good header |
| sector_o | output | 8 | Sector of the last good header |
| id_a_o | output | 8 | First disk ID byte of the last good header |
| id_b_o | output | 8 | Second disk ID byte of the last good header |
| hdr_ok_o | output | 1 | One-cycle pulse: header accepted |
| hdr_bad_o | output | 1 | One-cycle pulse: header rejected (checksum or sector range) |

## Verification
The known-good byte sequence is sent first. After it come headers with a broken checksum and with sector 20 and sector 21, which separates checksum failures from range failures at the range boundary. The same header is fed both with idle gaps between bytes and with a byte every cycle, so that field capture cannot depend on strobe spacing. Data-block leads, unknown leads, header look-alikes with no sync before them, a sync partway through a header and a sync that shares a cycle with a byte show that only the lead byte straight after a sync can start a capture.

// File: rtl/shp_pkg.sv
package shp_pkg;

    localparam int BYTE_W     = 8;
    localparam int BODY_BYTES = 5;          // checksum, sector, track, id a, id b
    localparam int SLOTS      = BODY_BYTES - 1;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t LEAD_HEADER = 8'h08;
    localparam byte_t LEAD_DATA   = 8'h07;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_LEAD,
        PS_BODY
    } parse_st_e;

    typedef enum logic [1:0] {
        LK_HEADER,
        LK_DATA,
        LK_OTHER
    } lead_kind_e;

    typedef struct packed {
        byte_t sum;
        byte_t sector;
        byte_t track;
        byte_t id_a;
    } body_t;

    function automatic byte_t fold_xor(input byte_t a, input byte_t b,
                                       input byte_t c, input byte_t d);
        return a ^ b ^ c ^ d;
    endfunction

endpackage

// File: rtl/shp_lead_decode.sv
module shp_lead_decode
    import shp_pkg::*;
(
    input  byte_t      lead_i,
    output lead_kind_e kind_o
);
    always_comb begin
        if (lead_i == LEAD_HEADER)
            kind_o = LK_HEADER;
        else if (lead_i == LEAD_DATA)
            kind_o = LK_DATA;
        else
            kind_o = LK_OTHER;
    end
endmodule

// File: rtl/shp_field_capture.sv
module shp_field_capture
    import shp_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int IDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      idx_i,
    input  byte_t                 dat_i,
    output logic [NSLOT-1:0][BYTE_W-1:0] slot_o
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_o[g] <= '0;
            else if (wr_en_i && (idx_i == IDX_W'(g)))
                slot_o[g] <= dat_i;
        end
    end
endmodule

// File: rtl/shp_header_judge.sv
module shp_header_judge
    import shp_pkg::*;
#(
    parameter int SECTORS_PER_TRACK = 21
) (
    input  body_t body_i,
    input  byte_t id_b_i,
    output logic  pass_o
);
    logic sum_match;
    logic sector_legal;

    always_comb begin
        sum_match    = (body_i.sum == fold_xor(body_i.sector, body_i.track,
                                               body_i.id_a, id_b_i));
        sector_legal = (body_i.sector < byte_t'(SECTORS_PER_TRACK));
        pass_o       = sum_match && sector_legal;
    end
endmodule

// File: rtl/sector_header_parser.sv
module sector_header_parser
    import shp_pkg::*;
#(
    parameter int SECTORS_PER_TRACK = 21
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_i,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    output logic [7:0] track_o,
    output logic [7:0] sector_o,
    output logic [7:0] id_a_o,
    output logic [7:0] id_b_o,
    output logic       hdr_ok_o,
    output logic       hdr_bad_o
);
    localparam int IDX_W = $clog2(BODY_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BODY_BYTES - 1);

    parse_st_e        state_q;
    logic [IDX_W-1:0] idx_q;
    lead_kind_e       lead_kind;
    logic             take, slot_wr, last_byte, pass;
    logic [SLOTS-1:0][BYTE_W-1:0] slots;
    body_t            body;

    shp_lead_decode u_lead (
        .lead_i (byte_i),
        .kind_o (lead_kind)
    );

    always_comb begin
        take      = (state_q == PS_BODY) && byte_vld_i && !sync_i;
        last_byte = take && (idx_q == LAST_IDX);
        slot_wr   = take && (idx_q != LAST_IDX);
        body.sum    = slots[0];
        body.sector = slots[1];
        body.track  = slots[2];
        body.id_a   = slots[3];
    end

    shp_field_capture #(.NSLOT(SLOTS), .IDX_W(IDX_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (slot_wr),
        .idx_i   (idx_q),
        .dat_i   (byte_i),
        .slot_o  (slots)
    );

    shp_header_judge #(.SECTORS_PER_TRACK(SECTORS_PER_TRACK)) u_judge (
        .body_i (body),
        .id_b_i (byte_i),
        .pass_o (pass)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            idx_q   <= '0;
        end else if (sync_i) begin
            state_q <= PS_LEAD;
            idx_q   <= '0;
        end else if (byte_vld_i) begin
            case (state_q)
                PS_LEAD: begin
                    state_q <= (lead_kind == LK_HEADER) ? PS_BODY : PS_IDLE;
                    idx_q   <= '0;
                end
                PS_BODY: begin
                    if (idx_q == LAST_IDX)
                        state_q <= PS_IDLE;
                    else
                        idx_q <= idx_q + 1'b1;
                end
                default: state_q <= PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            track_o   <= '0;
            sector_o  <= '0;
            id_a_o    <= '0;
            id_b_o    <= '0;
            hdr_ok_o  <= 1'b0;
            hdr_bad_o <= 1'b0;
        end else begin
            hdr_ok_o  <= last_byte && pass;
            hdr_bad_o <= last_byte && !pass;
            if (last_byte && pass) begin
                track_o  <= body.track;
                sector_o <= body.sector;
                id_a_o   <= body.id_a;
                id_b_o   <= byte_i;
            end
        end
    end

endmodule

// File: rtl/shp_checker.sv
module shp_checker #(
    parameter int SECTORS_PER_TRACK = 21
) (
    input logic       clk,
    input logic       rst,
    input logic       sync_i,
    input logic       byte_vld_i,
    input logic [7:0] track_o,
    input logic [7:0] sector_o,
    input logic [7:0] id_a_o,
    input logic [7:0] id_b_o,
    input logic       hdr_ok_o,
    input logic       hdr_bad_o
);
    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hdr_ok_o && hdr_bad_o));

    a_r11_ok_single: assert property (@(posedge clk) disable iff (rst)
        hdr_ok_o |=> !hdr_ok_o);

    a_r11_bad_single: assert property (@(posedge clk) disable iff (rst)
        hdr_bad_o |=> !hdr_bad_o);

    a_r3_fields_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable({track_o, sector_o, id_a_o, id_b_o}) |-> hdr_ok_o);

    a_r4_sector_range: assert property (@(posedge clk) disable iff (rst)
        hdr_ok_o |-> (int'(sector_o) < SECTORS_PER_TRACK));

    a_r2_after_byte: assert property (@(posedge clk) disable iff (rst)
        (hdr_ok_o || hdr_bad_o) |-> ($past(byte_vld_i) && !$past(sync_i)));
endmodule

bind sector_header_parser shp_checker #(.SECTORS_PER_TRACK(SECTORS_PER_TRACK)) chk_i (.*);

// File: tb/sector_header_parser_tb_top.sv
module sector_header_parser_tb_top;
    localparam int CLK_P = 10;
    localparam int SPT   = 21;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic [7:0] track_o, sector_o, id_a_o, id_b_o;
    logic       hdr_ok_o, hdr_bad_o;

    always #(CLK_P/2) clk = ~clk;

    sector_header_parser #(.SECTORS_PER_TRACK(SPT)) dut_i (
        .clk(clk), .rst(rst), .sync_i(sync_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .track_o(track_o), .sector_o(sector_o),
        .id_a_o(id_a_o), .id_b_o(id_b_o), .hdr_ok_o(hdr_ok_o),
        .hdr_bad_o(hdr_bad_o)
    );

    typedef struct {
        bit         ok;
        string      tag;
        logic [7:0] t, s, a, b;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] m_t = 0, m_s = 0, m_a = 0, m_b = 0;

    task automatic chk(input bit cond, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] xsum(input logic [7:0] s, t, a, b);
        return s ^ t ^ a ^ b;
    endfunction

    // monitor: pop and compare on every pulse
    always @(negedge clk) begin
        if (!rst && (hdr_ok_o || hdr_bad_o)) begin
            if (q.size() == 0) begin
                chk(0, "R5/R6/R7/R8", "unexpected pulse",
                    {hdr_ok_o, hdr_bad_o}, 0);
            end else begin
                e = q.pop_front();
                chk(hdr_ok_o == e.ok && hdr_bad_o == !e.ok, e.tag, "pulse kind",
                    {hdr_ok_o, hdr_bad_o}, {e.ok, !e.ok});
                chk({track_o, sector_o, id_a_o, id_b_o} == {e.t, e.s, e.a, e.b},
                    e.tag, "fields", {track_o, sector_o, id_a_o, id_b_o},
                    {e.t, e.s, e.a, e.b});
            end
        end
    end

    task automatic gap();
        @(negedge clk);
        byte_vld_i = 1'b0;
        sync_i = 1'b0;
    endtask

    task automatic put(input logic [7:0] b, input bit burst);
        @(negedge clk);
        sync_i = 1'b0;
        byte_vld_i = 1'b1;
        byte_i = b;
        if (!burst) gap();
    endtask

    task automatic sync_pulse();
        @(negedge clk);
        byte_vld_i = 1'b0;
        sync_i = 1'b1;
        gap();
    endtask

    task automatic body(input logic [7:0] sum, s, t, a, b, input bit burst);
        put(sum, burst); put(s, burst); put(t, burst);
        put(a, burst); put(b, burst);
        put(8'h0F, burst); put(8'h0F, burst);
        gap();
    endtask

    task automatic expect_ok(input string tag, input logic [7:0] t, s, a, b);
        q.push_back('{1'b1, tag, t, s, a, b});
        m_t = t; m_s = s; m_a = a; m_b = b;
    endtask

    task automatic expect_bad(input string tag);
        q.push_back('{1'b0, tag, m_t, m_s, m_a, m_b});
    endtask

    task automatic check_held(input string tag);
        repeat (3) gap();
        chk(q.size() == 0, tag, "pending events", q.size(), 0);
        chk({track_o, sector_o, id_a_o, id_b_o} == {m_t, m_s, m_a, m_b}, tag,
            "held fields", {track_o, sector_o, id_a_o, id_b_o},
            {m_t, m_s, m_a, m_b});
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({track_o, sector_o, id_a_o, id_b_o} == 32'h0, "R1", "fields",
            {track_o, sector_o, id_a_o, id_b_o}, 0);
        chk(!hdr_ok_o && !hdr_bad_o, "R1", "pulses", {hdr_ok_o, hdr_bad_o}, 0);
        @(negedge clk);
        rst = 1'b0;
        gap();

        // R9 / R2: known good vector, gapped bytes
        sync_pulse();
        expect_ok("R9", 8'h12, 8'h00, 8'hA0, 8'hAD);
        put(8'h08, 0);
        body(8'h1F, 8'h00, 8'h12, 8'hA0, 8'hAD, 0);
        check_held("R9");

        // R4 boundary sector 20 accepted, R11 back-to-back bytes
        sync_pulse();
        expect_ok("R4", 8'h23, 8'd20, 8'h31, 8'h32);
        put(8'h08, 1);
        body(xsum(8'd20, 8'h23, 8'h31, 8'h32), 8'd20, 8'h23, 8'h31, 8'h32, 1);
        check_held("R11");

        // R4: sector 21 with good checksum rejected
        sync_pulse();
        expect_bad("R4");
        put(8'h08, 0);
        body(xsum(8'd21, 8'h05, 8'h41, 8'h42), 8'd21, 8'h05, 8'h41, 8'h42, 0);
        check_held("R4");

        // R3: checksum mismatch
        sync_pulse();
        expect_bad("R3");
        put(8'h08, 1);
        body(8'h77, 8'h03, 8'h07, 8'h41, 8'h42, 1);
        check_held("R3");

        // R5: data block lead, then header look-alike bytes
        sync_pulse();
        put(8'h07, 0);
        put(8'h08, 0);
        body(xsum(8'h02, 8'h09, 8'h11, 8'h22), 8'h02, 8'h09, 8'h11, 8'h22, 0);
        check_held("R5");

        // R6: unknown lead
        sync_pulse();
        put(8'h55, 1);
        put(8'h08, 1);
        body(xsum(8'h02, 8'h09, 8'h11, 8'h22), 8'h02, 8'h09, 8'h11, 8'h22, 1);
        check_held("R6");

        // R7: sync mid-header, then full header
        sync_pulse();
        put(8'h08, 0); put(8'hAA, 0); put(8'h01, 0);
        sync_pulse();
        expect_ok("R7", 8'h0A, 8'h04, 8'h58, 8'h59);
        put(8'h08, 0);
        body(xsum(8'h04, 8'h0A, 8'h58, 8'h59), 8'h04, 8'h0A, 8'h58, 8'h59, 0);
        check_held("R7");

        // R8: header-like bytes with no sync after the fill
        put(8'h08, 0);
        body(xsum(8'h01, 8'h02, 8'h03, 8'h04), 8'h01, 8'h02, 8'h03, 8'h04, 0);
        check_held("R8");

        // R10: sync and byte in the same cycle, byte dropped
        @(negedge clk);
        sync_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'h08;
        gap();
        expect_ok("R10", 8'h11, 8'h06, 8'h33, 8'h34);
        put(8'h08, 0);
        body(xsum(8'h06, 8'h11, 8'h33, 8'h34), 8'h06, 8'h11, 8'h33, 8'h34, 0);
        check_held("R10");

        repeat (10) gap();
        chk(q.size() == 0, "R2", "all expected pulses seen", q.size(), 0);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule